// File: doc/BRIEF.md
# Dual-Rail Constructive Loop Evaluator

This block settles a two-gate cross-coupled loop, where X is I AND NOT Y and Y is J AND NOT X, by building a proof one step at a time instead of relying on two-valued logic. Each signal is carried as a pair of rails. One rail, when set, proves the signal is 1. The other, when set, proves it is 0. When neither is set, the value is not yet known. A start strobe captures the two inputs and clears both loop signals to unknown. After that, one propagation step runs on every clock. Each step can only add facts; it never removes one.

The evaluation ends on the first step that changes no rail. At that point a one-cycle done pulse is raised. A flag is also raised if any loop signal is still unknown, which means the loop has no constructive solution for those inputs. The resolved rails stay on the outputs until the next start. A controller can use the block to decide whether a feedback loop is well-behaved for a given input, and to read the values the loop settles to.

Top module: `cxl_eval`

## Requirements
- R1: Rail pairs are presented as {one, zero}: 2'b10 means logic 1, 2'b01 means logic 0, and 2'b00 means unknown. After reset, both outputs read 2'b00 and done and non_constructive are low.
- R2: A start strobe clears both loop signals to 2'b00 and clears non_constructive on the clock edge that samples it. This holds even if an evaluation is in progress.
- R3: With I=0 and J=1, the result is X=2'b01 and Y=2'b10 with non_constructive low, and done is high in the third cycle after the start edge.
- R4: With I=1 and J=0, the result is X=2'b10 and Y=2'b01 with non_constructive low, and done is high in the third cycle after the start edge.
- R5: With I=J=1, X and Y stay 2'b00, non_constructive is high, and done is high in the first cycle after the start edge.
- R6: With I=J=0, the result is X=2'b01 and Y=2'b01 with non_constructive low, and done is high in the second cycle after the start edge.
- R7: done lasts exactly one cycle. An evaluation never runs more than STEP_LIMIT propagation steps.
- R8: The two rails of a loop signal are never both 1.
- R9: Once a rail is set during an evaluation, it stays set until the next start.
- R10: I and J are sampled only on the start edge. Changing them during an evaluation does not alter the result or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new evaluation; captures in_i and in_j |
| in_i | input | 1 | Loop input feeding X |
| in_j | input | 1 | Loop input feeding Y |
| x_rail | output | 2 | X as {one, zero} rails |
| y_rail | output | 2 | Y as {one, zero} rails |
| done | output | 1 | One-cycle pulse when the evaluation has settled |
| non_constructive | output | 1 | Set with done when a loop signal is still unknown; held until next start |

## Verification
All four combinations of I and J are applied, and each one reaches a different outcome. The two asymmetric cases must resolve in opposite directions after two productive steps. I=J=0 resolves in a single step. I=J=1 must deadlock right away and be flagged. The exact cycle of the done pulse separates these cases by step count. The sweep is repeated with the inputs flipped just after start, to show they are latched. A restart issued in the middle of an evaluation shows that start clears the partial proof.

// File: rtl/cxl_pkg.sv
package cxl_pkg;

    // Rail pair: one=1 proves logic 1, zero=1 proves logic 0
    typedef struct packed {
        logic one;
        logic zero;
    } dual_t;

    localparam dual_t DR_UNKNOWN = '{one: 1'b0, zero: 1'b0};

    // A plain binary input is always fully known
    function automatic dual_t dr_from_bit(input logic b);
        dual_t d;
        d.one  = b;
        d.zero = ~b;
        return d;
    endfunction

    // Constructive a AND NOT b on rail pairs
    function automatic dual_t dr_and_not(input dual_t a, input dual_t b);
        dual_t d;
        d.one  = a.one & b.zero;
        d.zero = a.zero | b.one;
        return d;
    endfunction

    function automatic logic dr_known(input dual_t d);
        return d.one | d.zero;
    endfunction

endpackage

// File: rtl/cxl_step.sv
module cxl_step
    import cxl_pkg::*;
(
    input  dual_t [1:0] cur,
    input  logic  [1:0] lit,
    output dual_t [1:0] nxt,
    output logic        changed
);

    // Node k is driven by its own input and by the other node
    for (genvar k = 0; k < 2; k++) begin : g_node
        assign nxt[k] = dr_and_not(dr_from_bit(lit[k]), cur[1-k]);
    end

    assign changed = (nxt != cur);

endmodule

// File: rtl/cxl_ctrl.sv
module cxl_ctrl #(
    parameter int STEP_LIMIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic changed,
    output logic busy,
    output logic finish
);

    localparam int CW = $clog2(STEP_LIMIT + 1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;

    assign busy   = busy_q;
    assign finish = busy_q && !start &&
                    (!changed || cnt_q == CW'(STEP_LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (finish) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q < CW'(STEP_LIMIT))); // R7

endmodule

// File: rtl/cxl_eval.sv
module cxl_eval
    import cxl_pkg::*;
#(
    parameter int STEP_LIMIT = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       in_i,
    input  logic       in_j,
    output logic [1:0] x_rail,
    output logic [1:0] y_rail,
    output logic       done,
    output logic       non_constructive
);

    dual_t [1:0] state_q;   // [0]=X, [1]=Y
    dual_t [1:0] nxt;
    logic  [1:0] lit_q;     // [0]=I, [1]=J
    logic        changed;
    logic        busy;
    logic        finish;
    logic        done_q;
    logic        nc_q;

    cxl_step u_step (
        .cur     (state_q),
        .lit     (lit_q),
        .nxt     (nxt),
        .changed (changed)
    );

    cxl_ctrl #(.STEP_LIMIT(STEP_LIMIT)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .changed (changed),
        .busy    (busy),
        .finish  (finish)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= {DR_UNKNOWN, DR_UNKNOWN};
            lit_q   <= '0;
            done_q  <= 1'b0;
            nc_q    <= 1'b0;
        end else begin
            done_q <= finish;
            if (start) begin
                state_q <= {DR_UNKNOWN, DR_UNKNOWN};
                lit_q   <= {in_j, in_i};
                nc_q    <= 1'b0;
            end else if (busy) begin
                state_q <= nxt;
                if (finish)
                    nc_q <= !(dr_known(nxt[0]) && dr_known(nxt[1]));
            end
        end
    end

    assign x_rail           = state_q[0];
    assign y_rail           = state_q[1];
    assign done             = done_q;
    assign non_constructive = nc_q;

    AST_RAIL_EXCL_X: assert property (@(posedge clk) disable iff (rst)
        !(state_q[0].one && state_q[0].zero)); // R8
    AST_RAIL_EXCL_Y: assert property (@(posedge clk) disable iff (rst)
        !(state_q[1].one && state_q[1].zero)); // R8
    AST_MONOTONE: assert property (@(posedge clk) disable iff (rst)
        !start |=> ((state_q & $past(state_q)) == $past(state_q))); // R9
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start |=> (x_rail == 2'b00 && y_rail == 2'b00 && !non_constructive)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_NC_UNRESOLVED: assert property (@(posedge clk) disable iff (rst)
        (done && non_constructive) |-> (x_rail == 2'b00 && y_rail == 2'b00)); // R5

endmodule

// File: tb/cxl_eval_tb.sv
`timescale 1ns/1ps
module cxl_eval_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic       in_i;
    logic       in_j;
    logic [1:0] x_rail;
    logic [1:0] y_rail;
    logic       done;
    logic       non_constructive;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cxl_eval u_dut (
        .clk              (clk),
        .rst              (rst),
        .start            (start),
        .in_i             (in_i),
        .in_j             (in_j),
        .x_rail           (x_rail),
        .y_rail           (y_rail),
        .done             (done),
        .non_constructive (non_constructive)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic i, input logic j);
        if (i && j)       return "R5";
        else if (!i && j) return "R3";
        else if (i && !j) return "R4";
        else              return "R6";
    endfunction

    // One evaluation; flip toggles the inputs right after the start edge (R10)
    task automatic run_case(input logic i, input logic j, input logic flip);
        logic [1:0] ex, ey;
        logic       enc;
        int         lat;
        string      tg;
        logic [1:0] px, py;
        tg  = flip ? "R10" : tag_of(i, j);
        ex  = (i && j) ? 2'b00 : ((i && !j) ? 2'b10 : 2'b01);
        ey  = (i && j) ? 2'b00 : ((j && !i) ? 2'b10 : 2'b01);
        enc = i && j;
        lat = (i && j) ? 1 : ((i ^ j) ? 3 : 2);
        @(negedge clk);
        start = 1'b1; in_i = i; in_j = j;
        @(negedge clk);
        start = 1'b0;
        if (flip) begin in_i = ~i; in_j = ~j; end
        check("R2", {6'd0, x_rail}, 8'd0);
        check("R2", {6'd0, y_rail}, 8'd0);
        px = x_rail; py = y_rail;
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            check(tg, {7'd0, done}, {7'd0, (k == lat)});
            check("R9", {6'd0, x_rail & px}, {6'd0, px});
            check("R9", {6'd0, y_rail & py}, {6'd0, py});
            check("R8", {7'd0, &x_rail}, 8'd0);
            check("R8", {7'd0, &y_rail}, 8'd0);
            px = x_rail; py = y_rail;
        end
        check(tg, {6'd0, x_rail}, {6'd0, ex});
        check(tg, {6'd0, y_rail}, {6'd0, ey});
        check(tg, {7'd0, non_constructive}, {7'd0, enc});
        @(negedge clk);
        check("R7", {7'd0, done}, 8'd0);
        check("R1", {6'd0, x_rail}, {6'd0, ex});
        check(tg, {7'd0, non_constructive}, {7'd0, enc});
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; in_i = 1'b0; in_j = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {6'd0, x_rail}, 8'd0);
        check("R1", {6'd0, y_rail}, 8'd0);
        check("R1", {7'd0, done}, 8'd0);
        check("R1", {7'd0, non_constructive}, 8'd0);

        for (int f = 0; f < 2; f++)
            for (int c = 0; c < 4; c++)
                run_case(c[0], c[1], f[0]);

        // Restart in the middle of an evaluation (R2)
        @(negedge clk);
        start = 1'b1; in_i = 1'b0; in_j = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check("R3", {6'd0, x_rail}, 8'h01);
        start = 1'b1; in_i = 1'b1; in_j = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2", {6'd0, x_rail}, 8'd0);
        check("R2", {6'd0, y_rail}, 8'd0);
        check("R2", {7'd0, done}, 8'd0);
        @(negedge clk);
        check("R5", {7'd0, done}, 8'd1);
        check("R5", {7'd0, non_constructive}, 8'd1);
        @(negedge clk);
        check("R7", {7'd0, done}, 8'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule